// File: doc/BRIEF.md
# Multi-line Prefetch Burst Sequencer

This block turns one compact prefetch request into the DRAM commands that serve it. A request gives a bank, a row, the column of a starting cache line and a count of lines. All lines of a run sit in the same open row. The sequencer sends one row activate, then one column read per line. The final read of the run is flagged for auto-precharge, so the row closes without a separate precharge command.

A run is capped at a target number of column reads per activation. Other scheduling logic can hold the yield input high to make the sequencer step aside. It does this only between column reads. The read that is being loaded at that moment closes the row with auto-precharge, and the remaining lines are kept. When yield is released, the sequencer activates the row again and continues with the next line. Commands leave through a ready/valid handshake.

Top module: `pf_burst_seq`

## Requirements
- R1: After reset, busy, cmd_valid and cmd_autopre are 0, cmd_op is 2'b00 and req_ready is 1.
- R2: A request is taken only in a cycle where req_valid and req_ready are both 1. req_ready is 0 while busy is 1, and requests offered during a run have no effect on the commands issued.
- R3: Each activation of a run is a command with cmd_op = 2'b01 (activate) carrying the request's bank and row. It is followed directly by at least one command with cmd_op = 2'b10 (column read) to the same bank and row.
- R4: The number of reads in a run equals the request count clamped to the range 1 to CAP (default 4): a count of 0 gives one read, and a count above CAP gives CAP reads. No activation is followed by more than CAP reads.
- R5: Read k of a run (k from 0) uses the request's column above the low LINE_BITS bits (default 2) unchanged. Its low LINE_BITS bits equal the starting value plus k, modulo 2^LINE_BITS.
- R6: With yield held low, only the final read of a run has cmd_autopre = 1, and each non-final read is followed directly by the next read.
- R7: If yield_req is 1 at the clock edge where an activate or read is accepted and a further read is due, that next read carries cmd_autopre = 1. After it is accepted, no command is presented while yield_req stays 1. After yield_req is seen low, an activate is presented and the run resumes with the following line.
- R8: busy is 1 from the cycle after a request is accepted until the final read of the run has been accepted, and 0 in the cycle after that. cmd_valid is never 1 while busy is 0.
- R9: While cmd_valid is 1 and cmd_ready is 0, every command output holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_bank | input | BANK_W | Bank of the run |
| req_row | input | ROW_W | Row of the run |
| req_col | input | COL_W | Column of the first line |
| req_count | input | CNT_W | Number of lines requested |
| yield_req | input | 1 | Step aside between column reads |
| cmd_valid | output | 1 | Command presented |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_op | output | 2 | 2'b01 activate, 2'b10 read, 2'b00 none |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_row | output | ROW_W | Row of the command |
| cmd_col | output | COL_W | Column of a read (zero otherwise) |
| cmd_autopre | output | 1 | Read closes the row afterwards |
| busy | output | 1 | A run is in progress |

## Verification
The bench sweeps every starting line within a group of four, every count from 0 to 7, three yield patterns and two back-pressure patterns. Each accepted command is compared against an arithmetic expectation. Counts of 0 and above the cap catch a missing clamp, which would show up as zero reads or as a run that leaves its row and wraps the low column bits past the cap. Starting lines near the top of the group catch a carry into the upper column bits. Yield landing on the edge that accepts the activate, or a mid-run read, catches a design that forgets to close the row, loses the remaining count, skips the re-activate or repeats a line. Stalls catch outputs that change while waiting, and junk requests during a run catch a sequencer that accepts while busy.

// File: rtl/pf_burst_pkg.sv
// Shared encodings for the prefetch burst sequencer.
// Assumes: command op codes are decoded by the DRAM command path.
package pf_burst_pkg;

    typedef enum logic [1:0] {
        OP_NOP = 2'b00,
        OP_ACT = 2'b01,
        OP_RD  = 2'b10
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACT,
        ST_RD,
        ST_PARK
    } seq_state_e;

endpackage

// File: rtl/pf_req_clamp.sv
// Clamps a requested line count into the range 1..CAP.
// Assumes: CAP fits in CNT_W bits and is at least 1.
module pf_req_clamp #(
    parameter int CNT_W = 3,
    parameter int CAP   = 4
) (
    input  logic [CNT_W-1:0] raw_cnt,
    output logic [CNT_W-1:0] eff_cnt
);
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);
    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

    // Pick one line for zero, the cap for oversize, else the count itself.
    always_comb begin
        if (raw_cnt == '0)
            eff_cnt = ONE_V;
        else if (raw_cnt > CAP_V)
            eff_cnt = CAP_V;
        else
            eff_cnt = raw_cnt;
    end
endmodule

// File: rtl/pf_run_state.sv
// Holds the address and remaining count of the run being served.
// Assumes: load and step never coincide; step is one accepted read.
// The low LINE_BITS column bits advance modulo 2^LINE_BITS, upper bits stay.
module pf_run_state #(
    parameter int BANK_W    = 3,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 7,
    parameter int LINE_BITS = 2,
    parameter int CNT_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [BANK_W-1:0] ld_bank,
    input  logic [ROW_W-1:0]  ld_row,
    input  logic [COL_W-1:0]  ld_col,
    input  logic [CNT_W-1:0]  ld_cnt,
    output logic [BANK_W-1:0] run_bank,
    output logic [ROW_W-1:0]  run_row,
    output logic [COL_W-1:0]  cur_col,
    output logic              last_line,
    output logic              next_last
);
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [COL_W-1:0]  col_step;
    logic [CNT_W-1:0]  rem_q;

    // Column of the following line: wrap inside the line group.
    generate
        if (COL_W > LINE_BITS) begin : g_split
            always_comb
                col_step = {col_q[COL_W-1:LINE_BITS],
                            col_q[LINE_BITS-1:0] + LINE_BITS'(1)};
        end else begin : g_flat
            always_comb col_step = col_q + COL_W'(1);
        end
    endgenerate

    // Capture the run on load, advance one line per accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
            rem_q  <= '0;
        end else if (load) begin
            bank_q <= ld_bank;
            row_q  <= ld_row;
            col_q  <= ld_col;
            rem_q  <= ld_cnt;
        end else if (step) begin
            col_q <= col_step;
            rem_q <= rem_q - CNT_W'(1);
        end
    end

    assign run_bank  = bank_q;
    assign run_row   = row_q;
    assign cur_col   = col_q;
    assign last_line = (rem_q == CNT_W'(1));
    assign next_last = (rem_q == CNT_W'(2));
endmodule

// File: rtl/pf_cmd_issue.sv
// Command state machine: activate, reads, park on yield, re-activate.
// Assumes: yield_i is sampled on the edge that accepts the preceding
// command; the auto-precharge flag is registered so it holds while stalled.
module pf_cmd_issue
    import pf_burst_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    yield_i,
    input  logic    cmd_ready,
    input  logic    last_line,
    input  logic    next_last,
    output logic    accept,
    output logic    step,
    output logic    cmd_valid,
    output cmd_op_e op,
    output logic    autopre,
    output logic    busy,
    output logic    req_ready
);
    seq_state_e state_q;
    logic       ap_q;
    logic       fire;

    // Handshake decode from the current state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_valid && req_ready;
        cmd_valid = (state_q == ST_ACT) || (state_q == ST_RD);
        fire      = cmd_valid && cmd_ready;
        step      = fire && (state_q == ST_RD);
        busy      = (state_q != ST_IDLE);
        autopre   = (state_q == ST_RD) && ap_q;
        case (state_q)
            ST_ACT:  op = OP_ACT;
            ST_RD:   op = OP_RD;
            default: op = OP_NOP;
        endcase
    end

    // Sequence the run and decide the auto-precharge flag of each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ap_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    ap_q <= 1'b0;
                    if (accept) state_q <= ST_ACT;
                end
                ST_ACT: begin
                    if (cmd_ready) begin
                        state_q <= ST_RD;
                        ap_q    <= last_line || yield_i;
                    end
                end
                ST_RD: begin
                    if (cmd_ready) begin
                        if (ap_q) begin
                            state_q <= last_line ? ST_IDLE : ST_PARK;
                            ap_q    <= 1'b0;
                        end else begin
                            ap_q <= next_last || yield_i;
                        end
                    end
                end
                default: begin
                    if (!yield_i) state_q <= ST_ACT;
                end
            endcase
        end
    end
endmodule

// File: rtl/pf_burst_seq.sv
// Top of the prefetch burst sequencer: clamps the request, tracks the run
// and issues activate / read commands with auto-precharge on the closing read.
// Assumes: CAP <= 2**LINE_BITS and CAP < 2**CNT_W.
module pf_burst_seq
    import pf_burst_pkg::*;
#(
    parameter int BANK_W    = 3,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 7,
    parameter int LINE_BITS = 2,
    parameter int CAP       = 4,
    parameter int CNT_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              yield_req,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_autopre,
    output logic              busy
);
    logic [CNT_W-1:0] eff_cnt;
    logic             accept;
    logic             step;
    logic             last_line;
    logic             next_last;
    logic [COL_W-1:0] cur_col;
    cmd_op_e          op;

    pf_req_clamp #(.CNT_W(CNT_W), .CAP(CAP)) i_clamp (
        .raw_cnt (req_count),
        .eff_cnt (eff_cnt)
    );

    pf_run_state #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .LINE_BITS(LINE_BITS), .CNT_W(CNT_W)
    ) i_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .step      (step),
        .ld_bank   (req_bank),
        .ld_row    (req_row),
        .ld_col    (req_col),
        .ld_cnt    (eff_cnt),
        .run_bank  (cmd_bank),
        .run_row   (cmd_row),
        .cur_col   (cur_col),
        .last_line (last_line),
        .next_last (next_last)
    );

    pf_cmd_issue i_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .yield_i   (yield_req),
        .cmd_ready (cmd_ready),
        .last_line (last_line),
        .next_last (next_last),
        .accept    (accept),
        .step      (step),
        .cmd_valid (cmd_valid),
        .op        (op),
        .autopre   (cmd_autopre),
        .busy      (busy),
        .req_ready (req_ready)
    );

    // Present the column only on reads.
    assign cmd_op  = op;
    assign cmd_col = (op == OP_RD) ? cur_col : '0;
endmodule

// File: rtl/pf_burst_seq_chk.sv
// Protocol checker for pf_burst_seq, bound to every instance.
// Assumes: reset is synchronous and active low.
module pf_burst_seq_chk #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 7,
    parameter int CAP    = 4,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [1:0]        cmd_op,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [ROW_W-1:0]  cmd_row,
    input logic [COL_W-1:0]  cmd_col,
    input logic              cmd_autopre,
    input logic              busy
);
    logic [CNT_W:0] rd_since_act;
    logic           act_fire;
    logic           rd_fire;

    assign act_fire = cmd_valid && cmd_ready && (cmd_op == 2'b01);
    assign rd_fire  = cmd_valid && cmd_ready && (cmd_op == 2'b10);

    // Count accepted reads since the latest accepted activate.
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_since_act <= '0;
        else if (act_fire) rd_since_act <= '0;
        else if (rd_fire)  rd_since_act <= rd_since_act + 1'b1;
    end

    // R8
    busy_vs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    // R8
    valid_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) &&
        $stable(cmd_col) && $stable(cmd_autopre) && $stable(cmd_bank) &&
        $stable(cmd_row)));

    // R3
    act_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |=> (cmd_valid && cmd_op == 2'b10));

    // R6
    read_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && !cmd_autopre) |=> (cmd_valid && cmd_op == 2'b10));

    // R7
    close_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && cmd_autopre) |=> !cmd_valid);

    // R4
    reads_per_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_since_act <= (CNT_W+1)'(CAP));
endmodule

bind pf_burst_seq pf_burst_seq_chk #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .CAP(CAP), .CNT_W(CNT_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .cmd_bank    (cmd_bank),
    .cmd_row     (cmd_row),
    .cmd_col     (cmd_col),
    .cmd_autopre (cmd_autopre),
    .busy        (busy)
);

// File: tb/test_pf_burst_seq.sv
`timescale 1ns/1ps
// Sweep bench: every start line, count 0..7, yield and stall patterns.
module test_pf_burst_seq;
    localparam int BANK_W = 3, ROW_W = 14, COL_W = 7, LB = 2, CAP = 4, CNT_W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [CNT_W-1:0]  req_count = '0;
    logic yield_req = 1'b0, cmd_valid, cmd_ready = 1'b0;
    logic [1:0] cmd_op;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0]  cmd_row;
    logic [COL_W-1:0]  cmd_col;
    logic cmd_autopre, busy;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    pf_burst_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .LINE_BITS(LB), .CAP(CAP), .CNT_W(CNT_W)) i_pf_burst_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_count(req_count), .yield_req(yield_req), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_autopre(cmd_autopre),
        .busy(busy));

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1", "busy", busy, 0);
        chk(cmd_valid == 0, "R1", "cmd_valid", cmd_valid, 0);
        chk(cmd_autopre == 0, "R1", "cmd_autopre", cmd_autopre, 0);
        chk(cmd_op == 2'b00, "R1", "cmd_op", cmd_op, 0);
        chk(req_ready == 1, "R1", "req_ready", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int lo = 0; lo < 4; lo++)
        for (int cnt = 0; cnt < 8; cnt++)
        for (int yp = 0; yp < 3; yp++)
        for (int rp = 0; rp < 2; rp++) begin
            logic [BANK_W-1:0] bk;
            logic [ROW_W-1:0]  rw;
            logic [COL_W-LB-1:0] hi;
            int eff, k, remain, reads, cyc;
            bit parked, exp_act, exp_ap, active, y, r;

            bk  = BANK_W'(lo * 3 + cnt + yp);
            rw  = ROW_W'(lo * 977 + cnt * 131 + yp * 17 + rp * 5003);
            hi  = (COL_W-LB)'(cnt * 7 + lo * 5 + rp);
            eff = (cnt == 0) ? 1 : ((cnt > CAP) ? CAP : cnt);

            // Offer the request while idle.
            req_valid = 1'b1; req_bank = bk; req_row = rw;
            req_col = {hi, LB'(lo)}; req_count = CNT_W'(cnt);
            yield_req = 1'b0; cmd_ready = 1'b0;
            #1;
            chk(req_ready == 1, "R2", "req_ready idle", req_ready, 1);
            @(negedge clk);

            active = 1; parked = 0; exp_act = 1; exp_ap = 0;
            k = 0; remain = eff; reads = 0; cyc = 0;
            while (active && cyc < 300) begin
                // Junk request during the run must be ignored (R2).
                req_valid = 1'b1; req_bank = ~bk; req_row = ~rw;
                req_col = ~req_col; req_count = CNT_W'(cyc);
                y = (yp == 1) ? ((cyc % 4) == 1)
                  : (yp == 2) ? ((cyc % 6) >= 2 && (cyc % 6) <= 4) : 1'b0;
                r = (rp == 0) ? 1'b1 : ((cyc % 3) != 2);
                yield_req = y; cmd_ready = r;
                #1;
                chk(busy == 1, "R8", "busy during run", busy, 1);
                chk(req_ready == 0, "R2", "req_ready busy", req_ready, 0);
                chk(cmd_valid == !parked, "R7", "cmd_valid vs park",
                    cmd_valid, !parked);
                if (cmd_valid && !parked) begin
                    chk(cmd_bank == bk, "R2", "cmd_bank", cmd_bank, bk);
                    chk(cmd_row == rw, "R3", "cmd_row", cmd_row, rw);
                    if (exp_act) begin
                        chk(cmd_op == 2'b01, "R3", "op activate", cmd_op, 1);
                    end else begin
                        logic [COL_W-1:0] ec;
                        ec = {hi, LB'(lo + k)};
                        chk(cmd_op == 2'b10, "R3", "op read", cmd_op, 2);
                        chk(cmd_col == ec, "R5", "read column", cmd_col, ec);
                        chk(cmd_autopre == exp_ap, (yp == 0) ? "R6" : "R7",
                            "autopre", cmd_autopre, exp_ap);
                    end
                end
                // Advance the model across the coming edge.
                if (parked) begin
                    if (!y) parked = 0;
                end else if (cmd_valid && r) begin
                    if (exp_act) begin
                        exp_act = 0;
                        exp_ap = (remain == 1) || y;
                    end else begin
                        reads++; remain--; k++;
                        if (exp_ap) begin
                            if (remain == 0) active = 0;
                            else begin parked = 1; exp_act = 1; end
                        end else begin
                            exp_ap = (remain == 1) || y;
                        end
                    end
                end
                @(negedge clk);
                cyc++;
            end
            req_valid = 1'b0; yield_req = 1'b0; cmd_ready = 1'b0;
            #1;
            chk(reads == eff, "R4", "reads in run", reads, eff);
            chk(busy == 0, "R8", "busy after run", busy, 0);
            chk(cmd_valid == 0, "R8", "valid after run", cmd_valid, 0);
            chk(req_ready == 1, "R2", "ready after run", req_ready, 1);
            @(negedge clk);
        end
        finish_up();
    end
endmodule